// File: doc/BRIEF.md
# Channel Fault Flags and Alarm Controller

This block gathers protection events for a bank of low-side output channels. Each channel has two raw comparator inputs. One reports overcurrent while the channel is driven. The other reports that the output node is held low while the channel is off, which indicates an open load. Each raw input passes through its own deglitch counter, and a confirmed event sets a sticky bit in a fault word. An overcurrent bit also forces its channel off. An active-low alarm line is pulled low while any bit is set or while the die is hot.

The fault bits clear in one of two ways. Writing a channel's data bit to 0 clears that channel's overcurrent bit, and writing it to 1 clears its open-load bit. A global reset strobe clears the whole word. An over-temperature flag turns every channel off and pulls the alarm low for as long as it stays high, and it records nothing. An undervoltage flag clears every counter and every bit and keeps all channels off, and it leaves the alarm released.

Top module: `fault_alarm_ctrl`

## Requirements
- R1: The fault word is 2*NCH bits wide (16 by default). Bit NCH+i holds the overcurrent flag of channel i, and bit i holds its open-load flag. Channel i corresponds to bit i of every per-channel port.
- R2: An overcurrent flag sets on the OCP_LIM-th consecutive clock edge at which both its raw input and its data bit are sampled high. A single low sample restarts the count.
- R3: An open-load flag sets on the OL_LIM-th consecutive edge at which its raw input is sampled high while its data bit is 0. While the data bit is 1, the raw input has no effect.
- R4: While a channel's overcurrent flag is set, its kill output is high.
- R5: An edge with data_wr high clears the overcurrent flag of every channel whose data bit is 0 and the open-load flag of every channel whose data bit is 1. All other flags keep their values.
- R6: An edge with fault_clr high clears all flags, and this clear takes precedence over any set in the same edge. The deglitch counts are kept, so a condition that is still confirmed sets its flag again on the next edge.
- R7: With uv_low low, alarm_n is 0 in the same cycle if any flag is set or thermal_hot is high. Otherwise it is 1.
- R8: While thermal_hot is high, every kill output is high and no flag changes because of it. Once thermal_hot falls, the kill outputs follow the overcurrent flags again.
- R9: At each edge where uv_low is high, all flags and deglitch counts clear. While uv_low is high, every kill output is high and alarm_n is 1.
- R10: A flag stays set after its raw input falls until one of the clears in R5, R6 or R9 occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ocp_raw | input | NCH | Raw overcurrent comparator flags |
| ol_raw | input | NCH | Raw output-node-low flags used for open-load sensing |
| thermal_hot | input | 1 | Over-temperature flag |
| uv_low | input | 1 | Supply undervoltage flag |
| chan_on | input | NCH | Current data register, 1 = channel commanded on |
| data_wr | input | 1 | One-cycle strobe: chan_on was just written |
| fault_clr | input | 1 | One-cycle global fault reset strobe |
| fault_word | output | 2*NCH | Sticky fault word laid out as in R1 |
| alarm_n | output | 1 | Active-low alarm |
| chan_kill | output | NCH | Per-channel force-off |

## Verification
A deglitch count that is off by one shows up as a flag bit that sets one edge early or late. That bit appears on fault_word at the next falling edge, and a low alarm_n appears with it. A clear routed to the wrong half of the word, or to the wrong channel, leaves a stale bit that stays visible until the next clear. A count that survives an undervoltage event sets a flag too soon after the next short run of raw input. A per-cycle reference model compares all three outputs on every cycle, so each of these faults is reported within one cycle of its first visible effect.

// File: rtl/fault_pkg.sv
package fault_pkg;
  typedef struct packed {
    logic ocp;
    logic ol;
  } chan_flags_t;
endpackage

// File: rtl/fault_deglitch.sv
module fault_deglitch #(
  parameter int LIM = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_hi,
  input  logic clr,
  output logic hit
);
  localparam int CW = (LIM > 1) ? $clog2(LIM) : 1;
  localparam logic [CW-1:0] TOP = CW'(LIM - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | in_hi | (cnt_q != '0);
    if (clr || !in_hi)       cnt_d = '0;
    else if (cnt_q == TOP)   cnt_d = cnt_q;
    else                     cnt_d = cnt_q + 1'b1;
    hit = in_hi & ~clr & (cnt_q == TOP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP); // R2
  AST_CLR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (clr || !in_hi) |=> (cnt_q == '0)); // R9
  generate
    if (LIM > 1) begin : g_run
      AST_HIT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(in_hi)); // R2
    end
  endgenerate
endmodule

// File: rtl/fault_chan.sv
module fault_chan
  import fault_pkg::*;
#(
  parameter int OCP_LIM = 300,
  parameter int OL_LIM  = 1700
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ocp_raw,
  input  logic        ol_raw,
  input  logic        on,
  input  logic        wr,
  input  logic        clr_all,
  input  logic        uv,
  output chan_flags_t flags
);
  logic        ocp_hit, ol_hit, flags_en;
  chan_flags_t flags_d;

  fault_deglitch #(.LIM(OCP_LIM)) u_ocp_dg (
    .clk(clk), .rst_n(rst_n), .in_hi(ocp_raw & on), .clr(uv), .hit(ocp_hit));
  fault_deglitch #(.LIM(OL_LIM)) u_ol_dg (
    .clk(clk), .rst_n(rst_n), .in_hi(ol_raw & ~on), .clr(uv), .hit(ol_hit));

  always_comb begin
    flags_en = uv | clr_all | wr | ocp_hit | ol_hit;
    if (uv || clr_all) begin
      flags_d = '0;
    end else begin
      flags_d.ocp = (flags.ocp & ~(wr & ~on)) | ocp_hit;
      flags_d.ol  = (flags.ol  & ~(wr &  on)) | ol_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags <= '0;
    else if (flags_en) flags <= flags_d;
  end

  AST_OCP_SET_WHILE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags.ocp) |-> $past(on)); // R2
  AST_OL_SET_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags.ol) |-> !$past(on)); // R3
  AST_WR_OFF_CLEARS_OCP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !on) |=> !flags.ocp); // R5
  AST_WR_ON_CLEARS_OL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && on) |=> !flags.ol); // R5
  AST_GLOBAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all || uv) |=> (flags == '0)); // R6
  AST_OCP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.ocp && !clr_all && !uv && !(wr && !on)) |=> flags.ocp); // R10
endmodule

// File: rtl/fault_alarm_ctrl.sv
module fault_alarm_ctrl
  import fault_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int OCP_LIM = 300,
  parameter int OL_LIM  = 1700
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   ocp_raw,
  input  logic [NCH-1:0]   ol_raw,
  input  logic             thermal_hot,
  input  logic             uv_low,
  input  logic [NCH-1:0]   chan_on,
  input  logic             data_wr,
  input  logic             fault_clr,
  output logic [2*NCH-1:0] fault_word,
  output logic             alarm_n,
  output logic [NCH-1:0]   chan_kill
);
  localparam int FW = 2 * NCH;

  logic [1:0]     rst_pipe;
  logic           rst_n_s;
  logic [NCH-1:0] ocp_bits, ol_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      chan_flags_t fl;
      fault_chan #(.OCP_LIM(OCP_LIM), .OL_LIM(OL_LIM)) u_chan (
        .clk(clk), .rst_n(rst_n_s), .ocp_raw(ocp_raw[i]), .ol_raw(ol_raw[i]),
        .on(chan_on[i]), .wr(data_wr), .clr_all(fault_clr), .uv(uv_low),
        .flags(fl));
      assign ocp_bits[i] = fl.ocp;
      assign ol_bits[i]  = fl.ol;
    end
  endgenerate

  always_comb begin
    fault_word = {ocp_bits, ol_bits};
    chan_kill  = ocp_bits | {NCH{thermal_hot | uv_low}};
    alarm_n    = uv_low | ~((|fault_word) | thermal_hot);
  end

  AST_KILL_COVERS_OCP: assert property (@(posedge clk) disable iff (!rst_n_s)
    (fault_word[FW-1:NCH] & ~chan_kill) == '0); // R4
  AST_ALARM_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((|fault_word) && !uv_low) |-> !alarm_n); // R7
  AST_HOT_KILLS_ALL: assert property (@(posedge clk) disable iff (!rst_n_s)
    thermal_hot |-> (&chan_kill)); // R8
  AST_UV_SILENT: assert property (@(posedge clk) disable iff (!rst_n_s)
    uv_low |-> (alarm_n && (&chan_kill))); // R9
  AST_UV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_s)
    uv_low |=> (fault_word == '0)); // R9
endmodule

// File: tb/fault_alarm_ctrl_bench.sv
module fault_alarm_ctrl_bench;
  localparam int N    = 8;
  localparam int OCPL = 4;
  localparam int OLL  = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] ocp_raw, ol_raw, chan_on, chan_kill;
  logic thermal_hot, uv_low, data_wr, fault_clr, alarm_n;
  logic [2*N-1:0] fault_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int oc_run [N];
  int ol_run [N];
  logic [N-1:0] m_ocp, m_ol;

  always #5 clk = ~clk;

  fault_alarm_ctrl #(.NCH(N), .OCP_LIM(OCPL), .OL_LIM(OLL)) u_fault_alarm_ctrl (
    .clk(clk), .rst_n(rst_n), .ocp_raw(ocp_raw), .ol_raw(ol_raw),
    .thermal_hot(thermal_hot), .uv_low(uv_low), .chan_on(chan_on),
    .data_wr(data_wr), .fault_clr(fault_clr), .fault_word(fault_word),
    .alarm_n(alarm_n), .chan_kill(chan_kill));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_kill();
    return m_ocp | {N{thermal_hot | uv_low}};
  endfunction

  function automatic logic exp_alarm();
    return uv_low | ~((|m_ocp) | (|m_ol) | thermal_hot);
  endfunction

  task automatic model_step();
    logic [N-1:0] oh, lh;
    oh = '0; lh = '0;
    for (int i = 0; i < N; i++) begin
      if (uv_low) begin
        oc_run[i] = 0; ol_run[i] = 0;
      end else begin
        oc_run[i] = (ocp_raw[i] && chan_on[i]) ? ((oc_run[i] < OCPL) ? oc_run[i] + 1 : OCPL) : 0;
        ol_run[i] = (ol_raw[i] && !chan_on[i]) ? ((ol_run[i] < OLL) ? ol_run[i] + 1 : OLL) : 0;
        oh[i] = (oc_run[i] >= OCPL);
        lh[i] = (ol_run[i] >= OLL);
      end
    end
    if (uv_low || fault_clr) begin
      m_ocp = '0; m_ol = '0;
    end else begin
      m_ocp = (m_ocp & ~(data_wr ? ~chan_on : '0)) | oh;
      m_ol  = (m_ol  & ~(data_wr ?  chan_on : '0)) | lh;
    end
  endtask

  // one clock: model update at the edge, compare at the following falling edge
  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R1 word", 32'(fault_word), 32'({m_ocp, m_ol}));
    chk("R4 kill", 32'(chan_kill), 32'(exp_kill()));
    chk("R7 alarm", 32'(alarm_n), 32'(exp_alarm()));
    data_wr = 1'b0;
    fault_clr = 1'b0;
  endtask

  task automatic write_data(logic [N-1:0] v);
    chan_on = v; data_wr = 1'b1;
    step();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin oc_run[i] = 0; ol_run[i] = 0; end
    m_ocp = '0; m_ol = '0;
    rst_n = 1'b0; ocp_raw = '0; ol_raw = '0; chan_on = '0;
    thermal_hot = 1'b0; uv_low = 1'b0; data_wr = 1'b0; fault_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset word", 32'(fault_word), 32'h0);
    chk("R7 reset alarm", 32'(alarm_n), 32'h1);
    chk("R4 reset kill", 32'(chan_kill), 32'h0);

    // R2: short run does not set, full run does
    write_data(8'h01);
    ocp_raw = 8'h01;
    repeat (OCPL - 1) step();
    ocp_raw = 8'h00; step();
    chk("R2 short run", 32'(fault_word[8]), 32'h0);
    ocp_raw = 8'h01;
    repeat (OCPL - 1) step();
    chk("R2 one edge early", 32'(fault_word[8]), 32'h0);
    step();
    chk("R2 set", 32'(fault_word[8]), 32'h1);
    chk("R4 kill ch0", 32'(chan_kill[0]), 32'h1);
    chk("R7 alarm low", 32'(alarm_n), 32'h0);
    ocp_raw = 8'h00;
    repeat (3) step();
    chk("R10 sticky", 32'(fault_word), 32'h0100);
    write_data(8'h00);
    chk("R5 off clears ocp", 32'(fault_word), 32'h0);

    // R3: open load only while off
    write_data(8'h04);
    ol_raw = 8'h06;
    repeat (OLL) step();
    chk("R3 set while off", 32'(fault_word), 32'h0002);
    write_data(8'h06);
    chk("R5 on clears ol", 32'(fault_word), 32'h0);
    ol_raw = 8'h00;

    // R6: global clear then re-set from confirmed condition
    write_data(8'h00);
    ol_raw = 8'h80;
    repeat (OLL) step();
    chk("R6 pre", 32'(fault_word), 32'h0080);
    fault_clr = 1'b1; step();
    chk("R6 cleared", 32'(fault_word), 32'h0);
    step();
    chk("R6 re-set", 32'(fault_word), 32'h0080);

    // R8: thermal kills all, records nothing
    thermal_hot = 1'b1; step();
    chk("R8 kill all", 32'(chan_kill), 32'hFF);
    chk("R8 word kept", 32'(fault_word), 32'h0080);
    thermal_hot = 1'b0; step();
    chk("R8 release", 32'(chan_kill), 32'h00);

    // R9: undervoltage clears and stays silent
    uv_low = 1'b1; step();
    chk("R9 word", 32'(fault_word), 32'h0);
    chk("R9 alarm", 32'(alarm_n), 32'h1);
    chk("R9 kill", 32'(chan_kill), 32'hFF);
    uv_low = 1'b0;
    repeat (OLL - 1) step();
    chk("R9 count restarted", 32'(fault_word), 32'h0);
    step();
    chk("R9 after restart", 32'(fault_word), 32'h0080);
    ol_raw = '0;

    // random phase, every cycle compared against the model
    for (int c = 0; c < 4000; c++) begin
      if ($urandom % 8 == 0) ocp_raw = ocp_raw ^ N'(1 << ($urandom % N));
      if ($urandom % 8 == 0) ol_raw  = ol_raw  ^ N'(1 << ($urandom % N));
      if ($urandom % 16 == 0) begin chan_on = N'($urandom); data_wr = 1'b1; end
      if ($urandom % 64 == 0) fault_clr = 1'b1;
      if ($urandom % 60 == 0) thermal_hot = ~thermal_hot;
      uv_low = ($urandom % 150 == 0);
      step();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule